// File: doc/BRIEF.md
# Write-Protection Command Sequence Detector

This block watches the byte writes that a memory bus interface hands to a byte-wide non-volatile array and recognises short keyed command sequences in them. Each write arrives as an address, a data byte and a one-cycle strobe. From these sequences the block keeps a registered protected flag. For every write it also raises a same-cycle permit that tells the array controller whether that write may be committed.

Two key writes open every sequence: 0xAA to address 0x5555, then 0x55 to 0x2AAA. A third write of 0xA0 to 0x5555 ends the arming sequence. A third write of 0x80 to 0x5555 instead leads on to three more writes: 0xAA to 0x5555, 0x55 to 0x2AAA and 0x20 to 0x5555. Those three end the disarming sequence. A write that does not fit the expected next step drops the detector back to its start. While the flag is set, the arming sequence unlocks exactly one following data write. No other write is committed, and that includes the key writes themselves. While the array controller reports an internal write cycle in progress, the block ignores writes altogether.

Top module: `wp_seq_detect`

## Requirements
- R1: After reset, wp_active is 0. With wr_stb low, wr_commit is 0.
- R2: wr_commit is high only in a cycle in which wr_stb is high.
- R3: While wp_active is 0, every write presented with wr_busy low is committed in the same cycle. This includes the writes that form a key sequence.
- R4: Three accepted writes in a row, 0xAA@0x5555, 0x55@0x2AAA and 0xA0@0x5555, set wp_active to 1 in the cycle after the third write.
- R5: While wp_active is 1, completing the three-write arming sequence commits the next accepted write, whatever its address and data. The write after that is not committed unless a new arming sequence comes first. wp_active stays 1 throughout. The unlocked write ends any sequence in progress; it never starts a new one.
- R6: Six accepted writes in a row, 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and 0x20@0x5555, clear wp_active in the cycle after the sixth write. While wp_active is 1, none of the key writes is committed.
- R7: An accepted write that is not the expected next step returns the detector to its start, even if the write is itself 0xAA@0x5555. A later tail of the sequence then has no effect. While wp_active is 1, such a write is not committed.
- R8: A write presented with wr_busy high is never committed. It also leaves the sequence progress untouched, so a sequence that straddles it still completes.
- R9: wp_active changes only in the cycle after an accepted write that completes a full arming or disarming sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle strobe marking a bus write |
| wr_addr | input | 15 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| wr_busy | input | 1 | Internal write cycle in progress; writes are ignored |
| wr_commit | output | 1 | The write in this cycle may be committed to the array |
| wp_active | output | 1 | Registered write-protect state |

## Verification
wr_commit is combinational on the current write and the registered state, so it is due in the same cycle as the strobe. wp_active is due one clock edge after the write that completes a sequence. The bench changes its inputs on the falling edge and compares both outputs 1 ns later against a behavioural model. That model keeps the accepted writes of the current attempt in a queue and matches them against the two sequences. It advances only on the rising edge, so every comparison sees the state left by the write of the previous cycle. Directed scenarios cover aborted prefixes, busy writes inside a sequence, unlocked writes and partial disarm attempts.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // no key write seen
        ST_K1,     // first key write accepted
        ST_K2,     // second key write accepted
        ST_D1,     // branch toward disarm taken
        ST_D2,     // first key write of disarm tail
        ST_D3,     // second key write of disarm tail
        ST_UNLK    // one data write permitted while protected
    } wp_step_e;

    typedef struct packed {
        wp_step_e step;
        logic     prot;
    } wp_state_t;

    // key indices into the matcher hit vector
    localparam int unsigned K_OPEN  = 0; // first key pair
    localparam int unsigned K_CONF  = 1; // second key pair
    localparam int unsigned K_ARM   = 2; // arming code
    localparam int unsigned K_BRNCH = 3; // branch toward disarm
    localparam int unsigned K_DIS   = 4; // disarming code
    localparam int unsigned NUM_KEYS = 5;

endpackage

// File: rtl/wp_key_match.sv
module wp_key_match #(
    parameter int unsigned AW = 15,
    parameter int unsigned DW = 8,
    parameter int unsigned NK = 5,
    parameter logic [NK*AW-1:0] KEY_ADDR = '0,
    parameter logic [NK*DW-1:0] KEY_DATA = '0
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic [NK-1:0] hit
);

    genvar gi;
    generate
        for (gi = 0; gi < NK; gi++) begin : g_key
            localparam logic [AW-1:0] KA = KEY_ADDR[gi*AW +: AW];
            localparam logic [DW-1:0] KD = KEY_DATA[gi*DW +: DW];
            assign hit[gi] = (addr == KA) && (data == KD);
        end
    endgenerate

    // at most one key decodes for any write when the key pairs are distinct
    always_comb begin
        assert_keys_exclusive_R7: assert ($onehot0(hit))
            else $error("key decoder produced several hits");
    end

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int unsigned NK = NUM_KEYS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          busy,
    input  logic [NK-1:0] hit,
    output logic          commit,
    output logic          prot
);

    wp_state_t st_d, st_q;
    logic      accept;

    always_comb begin
        st_d   = st_q;
        accept = stb && !busy;
        if (accept) begin
            unique case (st_q.step)
                ST_IDLE: st_d.step = hit[K_OPEN] ? ST_K1 : ST_IDLE;
                ST_K1:   st_d.step = hit[K_CONF] ? ST_K2 : ST_IDLE;
                ST_K2: begin
                    if (hit[K_ARM]) begin
                        st_d.step = st_q.prot ? ST_UNLK : ST_IDLE;
                        st_d.prot = 1'b1;
                    end else if (hit[K_BRNCH]) begin
                        st_d.step = ST_D1;
                    end else begin
                        st_d.step = ST_IDLE;
                    end
                end
                ST_D1:   st_d.step = hit[K_OPEN] ? ST_D2 : ST_IDLE;
                ST_D2:   st_d.step = hit[K_CONF] ? ST_D3 : ST_IDLE;
                ST_D3: begin
                    st_d.step = ST_IDLE;
                    if (hit[K_DIS]) st_d.prot = 1'b0;
                end
                ST_UNLK: st_d.step = ST_IDLE;
                default: st_d.step = ST_IDLE;
            endcase
        end
        commit = accept && (!st_q.prot || st_q.step == ST_UNLK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{step: ST_IDLE, prot: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign prot = st_q.prot;

    assert_commit_needs_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> stb)
        else $error("commit without strobe");

    assert_busy_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !commit)
        else $error("commit during busy");

    assert_busy_holds_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q))
        else $error("state moved on a busy cycle");

    assert_prot_changes_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(st_q.prot))
        else $error("protect flag changed without a write");

    assert_arm_from_k2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step != ST_K2) |=> !$rose(st_q.prot))
        else $error("protect set outside arming step");

    assert_unlock_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prot && commit) |=> (st_q.step == ST_IDLE && st_q.prot))
        else $error("unlock not consumed after one write");

endmodule

// File: rtl/wp_seq_detect.sv
module wp_seq_detect
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_HI = 15'h5555,
    parameter logic [ADDR_W-1:0] ADDR_LO = 15'h2AAA,
    parameter logic [DATA_W-1:0] CODE_OPEN  = 8'hAA,
    parameter logic [DATA_W-1:0] CODE_CONF  = 8'h55,
    parameter logic [DATA_W-1:0] CODE_ARM   = 8'hA0,
    parameter logic [DATA_W-1:0] CODE_BRNCH = 8'h80,
    parameter logic [DATA_W-1:0] CODE_DIS   = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_busy,
    output logic              wr_commit,
    output logic              wp_active
);

    localparam int unsigned NK = NUM_KEYS;
    // packed key tables, index 0 in the least significant slot
    localparam logic [NK*ADDR_W-1:0] KEY_ADDR =
        {ADDR_HI, ADDR_HI, ADDR_HI, ADDR_LO, ADDR_HI};
    localparam logic [NK*DATA_W-1:0] KEY_DATA =
        {CODE_DIS, CODE_BRNCH, CODE_ARM, CODE_CONF, CODE_OPEN};

    logic [NK-1:0] key_hit;

    wp_key_match #(
        .AW(ADDR_W), .DW(DATA_W), .NK(NK),
        .KEY_ADDR(KEY_ADDR), .KEY_DATA(KEY_DATA)
    ) u_match (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (key_hit)
    );

    wp_ctrl #(.NK(NK)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb    (wr_stb),
        .busy   (wr_busy),
        .hit    (key_hit),
        .commit (wr_commit),
        .prot   (wp_active)
    );

endmodule

// File: tb/sim_wp_seq_detect.sv
module sim_wp_seq_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_busy = 1'b0;
    logic        wr_commit;
    logic        wp_active;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    wp_seq_detect u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_busy(wr_busy), .wr_commit(wr_commit),
        .wp_active(wp_active)
    );

    // behavioural reference
    logic [22:0] arm_seq [3];
    logic [22:0] dis_seq [6];
    logic [22:0] hist [$];
    bit m_prot = 0;
    bit m_unlock = 0;

    initial begin
        arm_seq = '{{15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'hA0}};
        dis_seq = '{{15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'h80},
                    {15'h5555, 8'hAA}, {15'h2AAA, 8'h55}, {15'h5555, 8'h20}};
    end

    function automatic bit prefix_of_arm();
        if (hist.size() > 3) return 0;
        foreach (hist[i]) if (hist[i] != arm_seq[i]) return 0;
        return 1;
    endfunction

    function automatic bit prefix_of_dis();
        if (hist.size() > 6) return 0;
        foreach (hist[i]) if (hist[i] != dis_seq[i]) return 0;
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_prot = 0; m_unlock = 0; hist.delete();
        end else if (wr_stb && !wr_busy) begin
            if (m_unlock) begin
                m_unlock = 0; hist.delete();
            end else begin
                hist.push_back({wr_addr, wr_data});
                if (!prefix_of_arm() && !prefix_of_dis()) begin
                    hist.delete();
                end else if (prefix_of_arm() && hist.size() == 3) begin
                    if (m_prot) m_unlock = 1;
                    m_prot = 1; hist.delete();
                end else if (prefix_of_dis() && hist.size() == 6) begin
                    m_prot = 0; hist.delete();
                end
            end
        end
    end

    // comparison every cycle, 1 ns after inputs change on the falling edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit exp_c;
            exp_c = wr_stb && !wr_busy && (!m_prot || m_unlock);
            checks++;
            if (wr_commit !== exp_c) begin
                errors++;
                $display("FAIL %s wr_commit actual=%0b expected=%0b", cur_tag, wr_commit, exp_c);
            end
            checks++;
            if (wp_active !== m_prot) begin
                errors++;
                $display("FAIL %s/R9 wp_active actual=%0b expected=%0b", cur_tag, wp_active, m_prot);
            end
        end
    end

    task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic b = 1'b0);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d; wr_busy = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_stb = 1'b0; wr_busy = 1'b0; wr_addr = '0; wr_data = '0;
        end
    endtask

    task automatic arm();
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
    endtask

    task automatic disarm();
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h20);
    endtask

    initial begin
        #50000;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values
        checks++;
        if (wp_active !== 1'b0 || wr_commit !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual=%0b%0b expected=00", wp_active, wr_commit);
        end
        @(negedge clk); rst_n = 1'b1;
        cur_tag = "R1"; idle(3);

        cur_tag = "R3"; // ordinary writes commit while unprotected
        wr(15'h0000, 8'h11); wr(15'h7FFF, 8'hFF); wr(15'h5555, 8'h00);
        cur_tag = "R2"; idle(2);

        cur_tag = "R7"; // wrong third write, then tail alone
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h33);
        wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
        wr(15'h5555, 8'hAA); wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
        wr(15'h5555, 8'hAA); wr(15'h2AAB, 8'h55); wr(15'h5555, 8'hA0);
        idle(2);

        cur_tag = "R8"; // busy writes inside the arming sequence
        wr(15'h5555, 8'hAA); wr(15'h0123, 8'h99, 1'b1);
        wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80, 1'b1);
        cur_tag = "R4";
        wr(15'h5555, 8'hA0);
        idle(2);

        cur_tag = "R6"; // protected: plain writes and key writes blocked
        wr(15'h0100, 8'h12); wr(15'h5555, 8'hAA); wr(15'h0200, 8'h34);
        idle(1);

        cur_tag = "R5"; // unlock exactly one write
        arm(); wr(15'h0100, 8'h12); wr(15'h0101, 8'h34);
        arm(); idle(2); wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
        arm(); wr(15'h7000, 8'h01, 1'b1); wr(15'h7000, 8'h02);
        idle(2);

        cur_tag = "R7"; // partial disarm with wrong last code
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h21);
        wr(15'h5555, 8'h20);
        idle(2);

        cur_tag = "R6"; // full disarm clears protection
        disarm(); idle(2);
        cur_tag = "R3";
        wr(15'h0042, 8'h5A); disarm(); wr(15'h0043, 8'hA5);
        cur_tag = "R4"; arm(); idle(1);
        cur_tag = "R9"; wr(15'h0001, 8'h01); idle(1); disarm(); idle(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule